// File: doc/BRIEF.md
# Three-Source Prioritised Interrupt Controller

This block gathers two external, level-sensitive interrupt request lines and one internal timer event into a single prioritised request for a CPU core. The core tells the block where each instruction ends and what its interrupt-disable flag is. The block answers with a one-cycle take pulse and a two-bit code naming the source to vector to. Vector fetch, stacking and the core itself live elsewhere.

Software reaches the block through a four-entry register window selected by two address bits. One entry holds a per-source disable mask. Another reports the raw pending state, and a write to it acknowledges the timer. Every write in the window also lands in a shared byte buffer, and the upper bits of the register reads come from that buffer. A request that becomes eligible is held back for one instruction boundary before it can be taken. A separate non-maskable input is latched on assertion and reported on its own output.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is 0, the buffer byte is 0x00, the timer request and the NMI flag are clear, the defer state is cleared and irq_take is 0.
- R2: A write at offset 2 keeps bits [2:0] of the data as the mask. A mask bit of 1 disables its source, using the same bit positions as the status register. A read at offset 2 returns the mask in [2:0] and buffer bits [7:3] above it.
- R3: Every write, at any offset, loads the whole data byte into the buffer. Reads at offsets 0 and 1 return the buffer unchanged.
- R4: A read at offset 3 returns ext_req2 in bit 0, ext_req1 in bit 1 and the timer request in bit 2, whatever the mask. Bits [7:3] come from the buffer.
- R5: A one-cycle tmr_fire pulse sets the timer request. Any write at offset 3 clears it, whatever the data. If tmr_fire and such a write fall in the same cycle, the request ends up set.
- R6: ext_req1 and ext_req2 are level-sensitive. Their pending bits follow the inputs, with no latching.
- R7: When several sources are eligible (pending and unmasked), the timer wins, then ext_req1, then ext_req2. irq_src encodes them as 0 for timer, 1 for ext_req1 and 2 for ext_req2, and holds its value between takes.
- R8: The first insn_end cycle that sees an eligible request only arms the block. A take happens at a later insn_end cycle while a request is still eligible. irq_take is high for exactly the one cycle after that insn_end cycle. A take disarms the block, so back-to-back takes need two boundaries each.
- R9: No take happens at a boundary while cpu_iflag is 1; the arming is kept until the flag clears. A masked source never arms or takes.
- R10: nmi_pending rises one cycle after nmi_in is high. Dropping nmi_in does not clear it; only reset does.
- R11: rd_data is registered. It shows the read value for the bus_addr of the previous cycle, and it is updated every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register window offset |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ext_req1 | input | 1 | External request, second priority |
| ext_req2 | input | 1 | External request, lowest priority |
| tmr_fire | input | 1 | Timer expiry pulse |
| nmi_in | input | 1 | Non-maskable request input |
| insn_end | input | 1 | Instruction-boundary strobe from the core |
| cpu_iflag | input | 1 | Core interrupt-disable flag |
| irq_take | output | 1 | One-cycle take pulse |
| irq_src | output | 2 | Source code of the last take |
| nmi_pending | output | 1 | Latched non-maskable request |

## Verification
On every cycle the assertions check several properties. A take only follows a boundary cycle with the disable flag low and an eligible request. No two takes are adjacent. The reported code never names a source that lost to a higher eligible one. The NMI latch never falls outside reset. The bench scenarios cover what depends on register contents and ordering: the exact read bytes with merged buffer bits, the timer acknowledge, the fire-versus-acknowledge collision, the count of boundaries before each take, and serving three simultaneous requests in priority order.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC     = 3;
  localparam int POS_REQ2 = 0;
  localparam int POS_REQ1 = 1;
  localparam int POS_TMR  = 2;
  localparam int SRC_W    = 2;

  // Source code: highest bit position maps to code 0
  typedef enum logic [SRC_W-1:0] {
    SRC_TMR  = 2'd0,
    SRC_REQ1 = 2'd1,
    SRC_REQ2 = 2'd2
  } src_e;

  localparam logic [1:0] OFS_MASK = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import prio_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ext1,
  input  logic              ext2,
  input  logic              tmr_fire,
  output logic [NSRC-1:0]   mask,
  output logic [NSRC-1:0]   pend,
  output logic [DATA_W-1:0] rdata
);
  localparam int UP_W = DATA_W - NSRC;

  logic [DATA_W-1:0] iobuf;
  logic              tmr_req;
  logic              ack_hit;

  assign ack_hit = wr_en && (addr[1:0] == OFS_STAT);

  always_comb begin
    pend           = '0;
    pend[POS_REQ2] = ext2;
    pend[POS_REQ1] = ext1;
    pend[POS_TMR]  = tmr_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iobuf   <= '0;
      mask    <= '0;
      tmr_req <= 1'b0;
    end else begin
      if (wr_en) iobuf <= wdata;
      if (wr_en && addr[1:0] == OFS_MASK) mask <= wdata[NSRC-1:0];
      if (tmr_fire)     tmr_req <= 1'b1;
      else if (ack_hit) tmr_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (addr[1:0])
        OFS_MASK: rdata <= {iobuf[DATA_W-1 -: UP_W], mask};
        OFS_STAT: rdata <= {iobuf[DATA_W-1 -: UP_W], pend};
        default:  rdata <= iobuf;
      endcase
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]     elig,
  output logic             any,
  output logic [SRC_W-1:0] code
);
  logic [N:0]             hit;
  logic [SRC_W-1:0]       stage [N+1];

  assign hit[0]   = 1'b0;
  assign stage[0] = '0;

  // Later stages override earlier ones: the highest bit position wins
  for (genvar i = 0; i < N; i++) begin : g_pri
    assign hit[i+1]   = hit[i] | elig[i];
    assign stage[i+1] = elig[i] ? SRC_W'(N-1-i) : stage[i];
  end

  assign any  = hit[N];
  assign code = stage[N];
endmodule

// File: rtl/irq_defer.sv
module irq_defer
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  input  logic             iflag,
  input  logic             any,
  input  logic [SRC_W-1:0] code,
  output logic             take,
  output logic [SRC_W-1:0] src
);
  logic armed;
  logic fire_now;

  assign fire_now = boundary && armed && any && !iflag;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      take  <= 1'b0;
      src   <= SRC_TMR;
    end else begin
      take <= fire_now;
      if (fire_now) src <= code;
      if (!any)          armed <= 1'b0;
      else if (boundary) armed <= !(armed && !iflag);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_req1,
  input  logic              ext_req2,
  input  logic              tmr_fire,
  input  logic              nmi_in,
  input  logic              insn_end,
  input  logic              cpu_iflag,
  output logic              irq_take,
  output logic [SRC_W-1:0]  irq_src,
  output logic              nmi_pending
);
  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  pend_vec;
  logic [NSRC-1:0]  elig_vec;
  logic             elig_any;
  logic [SRC_W-1:0] top_code;

  irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ext1(ext_req1), .ext2(ext_req2), .tmr_fire(tmr_fire),
    .mask(mask_q), .pend(pend_vec), .rdata(rd_data)
  );

  assign elig_vec = pend_vec & ~mask_q;

  irq_arbiter #(.N(NSRC)) u_arb (
    .elig(elig_vec), .any(elig_any), .code(top_code)
  );

  irq_defer u_defer (
    .clk(clk), .rst(rst), .boundary(insn_end), .iflag(cpu_iflag),
    .any(elig_any), .code(top_code), .take(irq_take), .src(irq_src)
  );

  always_ff @(posedge clk) begin
    if (rst)         nmi_pending <= 1'b0;
    else if (nmi_in) nmi_pending <= 1'b1;
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       insn_end,
  input logic       cpu_iflag,
  input logic       irq_take,
  input logic [1:0] irq_src,
  input logic       nmi_pending,
  input logic [2:0] elig_vec
);
  assert_take_after_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> ($past(insn_end) && $past(|elig_vec)));

  assert_no_take_when_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> !$past(cpu_iflag));

  assert_no_adjacent_takes_R8: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !irq_take);

  assert_lowest_only_alone_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_src == 2'd2) |-> (!$past(elig_vec[2]) && !$past(elig_vec[1])));

  assert_mid_below_timer_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_src == 2'd1) |-> !$past(elig_vec[2]));

  assert_valid_code_R7: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (irq_src != 2'd3));

  assert_nmi_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    nmi_pending |=> nmi_pending);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .insn_end(insn_end), .cpu_iflag(cpu_iflag),
  .irq_take(irq_take), .irq_src(irq_src), .nmi_pending(nmi_pending),
  .elig_vec(elig_vec)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  localparam int K_RD = 0, K_TAKE = 1, K_NMI = 2;

  typedef struct {
    string      req;
    int         kind;
    logic [7:0] val;
  } item_t;

  logic       clk = 0, rst = 1;
  logic       bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] rd_data;
  logic       ext_req1 = 0, ext_req2 = 0, tmr_fire = 0, nmi_in = 0;
  logic       insn_end = 0, cpu_iflag = 0;
  logic       irq_take, nmi_pending;
  logic [1:0] irq_src;
  logic       probe_rd = 0, probe_nmi = 0;
  int         n_cmp = 0, n_bad = 0;
  item_t      exp_q[$];

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .ext_req1(ext_req1),
    .ext_req2(ext_req2), .tmr_fire(tmr_fire), .nmi_in(nmi_in),
    .insn_end(insn_end), .cpu_iflag(cpu_iflag), .irq_take(irq_take),
    .irq_src(irq_src), .nmi_pending(nmi_pending)
  );

  task automatic check_item(int kind, logic [7:0] got);
    item_t it;
    n_cmp++;
    if (exp_q.size() == 0 || exp_q[0].kind != kind) begin
      n_bad++;
      $display("FAIL unexpected event kind %0d: actual %h expected none", kind, got);
    end else begin
      it = exp_q.pop_front();
      if (got !== it.val) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, got, it.val);
      end
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_take)  check_item(K_TAKE, {6'b0, irq_src});
      if (probe_rd)  check_item(K_RD, rd_data);
      if (probe_nmi) check_item(K_NMI, {7'b0, nmi_pending});
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] e, string req);
    bus_addr = a;
    tick(1);
    exp_q.push_back('{req, K_RD, e});
    probe_rd = 1;
    tick(1);
    probe_rd = 0;
  endtask

  task automatic nmi_chk(logic e, string req);
    exp_q.push_back('{req, K_NMI, {7'b0, e}});
    probe_nmi = 1;
    tick(1);
    probe_nmi = 0;
  endtask

  task automatic boundary();
    insn_end = 1;
    tick(1);
    insn_end = 0;
    tick(1);
  endtask

  task automatic boundary_take(logic [1:0] src, string req);
    exp_q.push_back('{req, K_TAKE, {6'b0, src}});
    boundary();
  endtask

  task automatic fire();
    tmr_fire = 1;
    tick(1);
    tmr_fire = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state, R11 registered read
    rd_chk(2'd2, 8'h00, "R1 mask after reset");
    rd_chk(2'd3, 8'h00, "R1 status after reset");
    nmi_chk(1'b0, "R1 nmi clear after reset");
    // R3 buffer
    wr(2'd0, 8'hA5);
    rd_chk(2'd0, 8'hA5, "R3 offset0 buffer");
    rd_chk(2'd1, 8'hA5, "R3 offset1 buffer");
    // R2 mask with merged buffer bits
    wr(2'd2, 8'h06);
    wr(2'd1, 8'h81);
    rd_chk(2'd2, 8'h86, "R2 mask merged with buffer");
    // R4 status, R5 timer set
    wr(2'd2, 8'h00);
    ext_req1 = 1;
    fire();
    rd_chk(2'd3, 8'h06, "R4 status timer and req1");
    wr(2'd0, 8'hF8);
    rd_chk(2'd3, 8'hFE, "R4 status upper from buffer");
    // R5 ack ignores data
    wr(2'd3, 8'hFF);
    rd_chk(2'd3, 8'hFA, "R5 timer cleared by ack");
    ext_req1 = 0;
    tick(1);
    // R7 priority, R8 deferral
    ext_req1 = 1; ext_req2 = 1;
    fire();
    boundary();
    boundary_take(2'd0, "R7 timer first R8");
    wr(2'd3, 8'h00);
    boundary();
    boundary_take(2'd1, "R7 req1 second");
    ext_req1 = 0;
    boundary();
    boundary_take(2'd2, "R7 req2 last");
    ext_req2 = 0;
    // R6 level follows input
    rd_chk(2'd3, 8'h00, "R6 status follows dropped lines");
    // R9 disable flag
    ext_req1 = 1; cpu_iflag = 1;
    boundary();
    boundary();
    boundary();
    cpu_iflag = 0;
    boundary_take(2'd1, "R9 take after flag clears");
    ext_req1 = 0;
    tick(1);
    // R9 masked source
    wr(2'd2, 8'h02);
    ext_req1 = 1;
    boundary();
    boundary();
    rd_chk(2'd3, 8'h02, "R4 masked source still shown");
    ext_req1 = 0;
    tick(1);
    wr(2'd2, 8'h00);
    // R10 NMI latch
    nmi_in = 1;
    tick(1);
    nmi_in = 0;
    tick(2);
    nmi_chk(1'b1, "R10 nmi held after deassert");
    // R5 fire and ack together
    tmr_fire = 1;
    wr(2'd3, 8'h40);
    tmr_fire = 0;
    rd_chk(2'd3, 8'h44, "R5 fire wins over ack");
    wr(2'd3, 8'h00);
    rd_chk(2'd3, 8'h00, "R5 ack clears timer");
    tick(4);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8 missing events: actual %0d left expected 0", exp_q.size());
    end
    summary();
  end
endmodule